// File: doc/BRIEF.md
# Flash Program Command Sequencer

This block sits on the host side of a parallel NOR flash bus. It turns a single request into the bus write cycles that the flash command interface needs. A request can program one word, enter the fast-programming bypass state, or leave that state. The sequencer drives chip enable, write enable, output enable, address and data. Each bus write has a one-clock setup, a write-enable-low pulse of `PULSE_W` clocks, and a one-clock hold. The sequencer never reads, so output enable stays high.

A flag records whether the device has been placed in bypass. In bypass a program takes two bus writes; otherwise it takes four. Raising `accel_req` forces the two-write form while it stays high. Lowering it returns the sequencer to whatever mode the commands alone had set.

The controller has four named states:
- `S_IDLE`: bus released.
- `S_SETUP`: chip enable low, write enable high.
- `S_PULSE`: both low.
- `S_HOLD`: write enable back high.

Its transitions are:
- `IDLE→SETUP`: a request is accepted.
- `SETUP→PULSE`: always.
- `PULSE→HOLD`: the pulse counter expires.
- `HOLD→SETUP`: more writes remain in the sequence.
- `HOLD→IDLE`: the last write is done.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are high, `busy` and `done` are low, `bypass_active` is low, and no bus write occurs.
- R2: Every bus write follows the same pattern, with `flash_oe_n` held high throughout:
  - `flash_ce_n` stays low for the whole write.
  - One clock has `flash_we_n` high (setup).
  - `flash_we_n` is then low for exactly `PULSE_W` clocks.
  - One clock follows with `flash_we_n` high (hold).
  - Address and data stay constant while `flash_we_n` is low.
- R3: `cmd_op`=00 (program) with bypass off issues four writes in order as (address, data): (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), then (`cmd_addr`,`cmd_data`).
- R4: `cmd_op`=01 (enter bypass) issues (0x555,0xAA), (0x2AA,0x55), (0x555,0x20). `bypass_active` is high from the cycle after `done`.
- R5: `cmd_op`=00 with bypass on issues two writes: (0x000,0xA0), then (`cmd_addr`,`cmd_data`).
- R6: `cmd_op`=10 (exit bypass) issues (0x000,0x90), then (0x000,0x00). Afterwards `bypass_active` is low, unless `accel_req` is high.
- R7: While `accel_req` is high, `bypass_active` is high and a program uses the two-write form. Once it is low, the command-set mode applies again.
- R8: `busy` rises the clock after acceptance and stays high for exactly N×(`PULSE_W`+2) clocks for an N-write sequence. `done` is a one-clock pulse in the first clock that `busy` is low. Requests made while `busy` is high are ignored.
- R9: `cmd_op`=11 is reserved. It is ignored: it causes no busy, no done and no bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request strobe, taken when idle |
| cmd_op | input | 2 | 00 program, 01 enter bypass, 10 exit bypass, 11 reserved |
| cmd_addr | input | AW | Target word address for program |
| cmd_data | input | DW | Word to program |
| accel_req | input | 1 | Forces two-write programming while high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| bypass_active | output | 1 | Programs currently use the two-write form |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low (held high) |
| flash_addr | output | AW | Flash address bus |
| flash_dq | output | DW | Flash data bus |

## Verification
Two events can fall in the same clock:
- completion of one sequence (`done` high, `busy` low);
- the presentation of the next request.

The bench also presents a request while a program is still running. It judges that the blocked request adds no bus write, using a scoreboard of expected (address, data) pairs that must be empty at the end. A request issued right after `done` must start on the next edge, with its writes in order. Mode changes are judged by whether the next program produces two or four writes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_ENTER = 2'b01,
        OP_EXIT  = 2'b10,
        OP_RSVD  = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        SQ_STD,
        SQ_BYP,
        SQ_ENTER,
        SQ_EXIT
    } seq_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETUP,
        S_PULSE,
        S_HOLD
    } bus_state_e;

    localparam logic [11:0] UNLOCK_A = 12'h555;
    localparam logic [11:0] UNLOCK_B = 12'h2AA;
    localparam logic [7:0]  KEY_1    = 8'hAA;
    localparam logic [7:0]  KEY_2    = 8'h55;
    localparam logic [7:0]  KEY_PROG = 8'hA0;
    localparam logic [7:0]  KEY_BYP  = 8'h20;
    localparam logic [7:0]  KEY_EX1  = 8'h90;
    localparam logic [7:0]  KEY_EX2  = 8'h00;

endpackage

// File: rtl/flash_step_rom.sv
module flash_step_rom
    import flash_seq_pkg::*;
#(
    parameter int AW = 22,
    parameter int DW = 16
) (
    input  seq_kind_e         kind,
    input  logic [1:0]        step,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              last
);

    function automatic logic [AW-1:0] xa(input logic [11:0] a);
        return AW'(a);
    endfunction

    function automatic logic [DW-1:0] xd(input logic [7:0] d);
        return DW'(d);
    endfunction

    always_comb begin
        wr_addr = '0;
        wr_data = '0;
        last    = 1'b0;
        unique case (kind)
            SQ_STD: begin
                unique case (step)
                    2'd0: begin wr_addr = xa(UNLOCK_A); wr_data = xd(KEY_1); end
                    2'd1: begin wr_addr = xa(UNLOCK_B); wr_data = xd(KEY_2); end
                    2'd2: begin wr_addr = xa(UNLOCK_A); wr_data = xd(KEY_PROG); end
                    default: begin wr_addr = tgt_addr; wr_data = tgt_data; last = 1'b1; end
                endcase
            end
            SQ_BYP: begin
                if (step == 2'd0) begin
                    wr_data = xd(KEY_PROG);
                end else begin
                    wr_addr = tgt_addr;
                    wr_data = tgt_data;
                    last    = 1'b1;
                end
            end
            SQ_ENTER: begin
                unique case (step)
                    2'd0:    begin wr_addr = xa(UNLOCK_A); wr_data = xd(KEY_1); end
                    2'd1:    begin wr_addr = xa(UNLOCK_B); wr_data = xd(KEY_2); end
                    default: begin wr_addr = xa(UNLOCK_A); wr_data = xd(KEY_BYP); last = 1'b1; end
                endcase
            end
            SQ_EXIT: begin
                if (step == 2'd0) begin
                    wr_data = xd(KEY_EX1);
                end else begin
                    wr_data = xd(KEY_EX2);
                    last    = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
    parameter int PULSE_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(PULSE_W) + 1;
    localparam logic [CW-1:0] RELOAD = CW'(PULSE_W - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= RELOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int AW      = 22,
    parameter int DW      = 16,
    parameter int PULSE_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          accel_req,
    output logic          busy,
    output logic          done,
    output logic          bypass_active,
    output logic          flash_ce_n,
    output logic          flash_we_n,
    output logic          flash_oe_n,
    output logic [AW-1:0] flash_addr,
    output logic [DW-1:0] flash_dq
);

    bus_state_e    state_q, state_d;
    seq_kind_e     kind_q;
    logic [1:0]    step_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          done_q, bypass_q;
    logic          accept, pulse_end, step_last;
    logic [AW-1:0] step_addr;
    logic [DW-1:0] step_data;
    seq_kind_e     new_kind;

    assign bypass_active = bypass_q | accel_req;
    assign accept = cmd_valid && (state_q == S_IDLE) && (cmd_op != OP_RSVD);

    always_comb begin
        unique case (cmd_op)
            OP_ENTER: new_kind = SQ_ENTER;
            OP_EXIT:  new_kind = SQ_EXIT;
            default:  new_kind = bypass_active ? SQ_BYP : SQ_STD;
        endcase
    end

    flash_step_rom #(.AW(AW), .DW(DW)) u_rom (
        .kind     (kind_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (step_addr),
        .wr_data  (step_data),
        .last     (step_last)
    );

    flash_pulse_timer #(.PULSE_W(PULSE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == S_SETUP),
        .expired (pulse_end)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept)    state_d = S_SETUP;
            S_SETUP:                state_d = S_PULSE;
            S_PULSE: if (pulse_end) state_d = S_HOLD;
            S_HOLD:  state_d = step_last ? S_IDLE : S_SETUP;
            default:                state_d = S_IDLE;
        endcase
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            kind_q   <= SQ_STD;
            step_q   <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            done_q   <= 1'b0;
            bypass_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= 1'b0;
            if (accept) begin
                kind_q <= new_kind;
                step_q <= '0;
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
            if (state_q == S_HOLD) begin
                if (step_last) begin
                    done_q <= 1'b1;
                    if (kind_q == SQ_ENTER) bypass_q <= 1'b1;
                    if (kind_q == SQ_EXIT)  bypass_q <= 1'b0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // output decode
    always_comb begin
        flash_oe_n = 1'b1;
        flash_addr = step_addr;
        flash_dq   = step_data;
        unique case (state_q)
            S_IDLE:  begin flash_ce_n = 1'b1; flash_we_n = 1'b1; end
            S_SETUP: begin flash_ce_n = 1'b0; flash_we_n = 1'b1; end
            S_PULSE: begin flash_ce_n = 1'b0; flash_we_n = 1'b0; end
            S_HOLD:  begin flash_ce_n = 1'b0; flash_we_n = 1'b1; end
            default: begin flash_ce_n = 1'b1; flash_we_n = 1'b1; end
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign done = done_q;

    // R2: write enable only goes low inside a chip-enable window
    a_r2_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> !flash_ce_n);
    // R2: a falling write enable is preceded by a setup clock with chip enable low
    a_r2_setup_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we_n) |-> $past(!flash_ce_n && flash_we_n));
    // R2: address and data are steady during the pulse
    a_r2_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq)));
    // R8: done comes in the first idle clock after busy
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R8: a request while busy does not disturb the latched target
    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(addr_q) && $stable(data_q)));
    // R9: reserved op from idle starts nothing
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op == 2'b11) |=> !busy);

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          accel_req = 1'b0;
    logic          busy, done, bypass_active;
    logic          flash_ce_n, flash_we_n, flash_oe_n;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_dq;

    int checks = 0;
    int errors = 0;
    logic [AW+DW-1:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_seq #(.AW(AW), .DW(DW), .PULSE_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .accel_req(accel_req),
        .busy(busy), .done(done), .bypass_active(bypass_active),
        .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n),
        .flash_addr(flash_addr), .flash_dq(flash_dq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] a, input logic [7:0] d);
        expq.push_back({AW'(a), DW'(d)});
    endtask

    // monitor: compares every completed write against the scoreboard (R2..R6)
    logic          prev_we = 1'b1;
    int            low_cnt = 0;
    logic [AW-1:0] cap_a;
    logic [DW-1:0] cap_d;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!flash_we_n) begin
                if (low_cnt > 0)
                    check(cap_a == flash_addr && cap_d == flash_dq, "R2", "bus stable",
                          {flash_addr, flash_dq}, {cap_a, cap_d});
                cap_a = flash_addr;
                cap_d = flash_dq;
                low_cnt++;
                check(!flash_ce_n && flash_oe_n, "R2", "ce low oe high in pulse",
                      {flash_ce_n, flash_oe_n}, 2'b01);
            end else if (!prev_we) begin
                check(low_cnt == PW, "R2", "pulse width", low_cnt, PW);
                if (expq.size() == 0) begin
                    check(0, "R8", "unexpected write", {cap_a, cap_d}, 0);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = expq.pop_front();
                    check({cap_a, cap_d} == e, "R3-6 order", "write addr/data",
                          {cap_a, cap_d}, e);
                end
                low_cnt = 0;
            end
            prev_we = flash_we_n;
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int nwr, input string req,
                          input bit poke_busy);
        int bcnt = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && bcnt < 1000) begin
            if (busy) bcnt++;
            if (poke_busy && bcnt == 4) begin
                cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 22'h3FFFF; cmd_data = 16'hDEAD;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(bcnt == nwr * (PW + 2), "R8", {req, " busy length"}, bcnt, nwr * (PW + 2));
        check(done && !busy, "R8", "done pulse with busy low", {done, busy}, 2'b10);
        check(expq.size() == 0, req, "all expected writes seen", expq.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        check(flash_ce_n && flash_we_n && flash_oe_n, "R1", "bus idle in reset",
              {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
        check(!busy && !done && !bypass_active, "R1", "status in reset",
              {busy, done, bypass_active}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(flash_ce_n && !busy, "R1", "idle after reset", {flash_ce_n, busy}, 2'b10);

        // R3 standard program, with a request poked while busy (R8)
        push(12'h555, 8'hAA); push(12'h2AA, 8'h55); push(12'h555, 8'hA0);
        expq.push_back({22'h012345, 16'hBEEF});
        run_op(2'b00, 22'h012345, 16'hBEEF, 4, "R3", 1'b1);
        repeat (30) @(negedge clk);
        check(expq.size() == 0 && !busy, "R8", "request during busy ignored", busy, 0);

        // R9 reserved op
        cmd_valid = 1'b1; cmd_op = 2'b11;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (5) begin
            check(!busy && !done && flash_ce_n, "R9", "reserved op ignored",
                  {busy, done, flash_ce_n}, 3'b001);
            @(negedge clk);
        end

        // R4 enter bypass
        push(12'h555, 8'hAA); push(12'h2AA, 8'h55); push(12'h555, 8'h20);
        run_op(2'b01, '0, '0, 3, "R4", 1'b0);
        @(negedge clk);
        check(bypass_active, "R4", "bypass flag set", bypass_active, 1);

        // R5 bypass program, then a back-to-back one issued right after done
        push(12'h000, 8'hA0); expq.push_back({22'h2AAAAA, 16'h1234});
        run_op(2'b00, 22'h2AAAAA, 16'h1234, 2, "R5", 1'b0);
        push(12'h000, 8'hA0); expq.push_back({22'h000777, 16'hFFFF});
        run_op(2'b00, 22'h000777, 16'hFFFF, 2, "R5", 1'b0);

        // R6 exit bypass
        push(12'h000, 8'h90); push(12'h000, 8'h00);
        run_op(2'b10, '0, '0, 2, "R6", 1'b0);
        @(negedge clk);
        check(!bypass_active, "R6", "bypass flag cleared", bypass_active, 0);

        // R7 accelerate forces two-write programs
        accel_req = 1'b1;
        @(negedge clk);
        check(bypass_active, "R7", "accel forces bypass", bypass_active, 1);
        push(12'h000, 8'hA0); expq.push_back({22'h100001, 16'h5A5A});
        run_op(2'b00, 22'h100001, 16'h5A5A, 2, "R7", 1'b0);
        accel_req = 1'b0;
        @(negedge clk);
        check(!bypass_active, "R7", "accel removed", bypass_active, 0);
        push(12'h555, 8'hAA); push(12'h2AA, 8'h55); push(12'h555, 8'hA0);
        expq.push_back({22'h000000, 16'h0001});
        run_op(2'b00, 22'h000000, 16'h0001, 4, "R7", 1'b0);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule